// File: doc/BRIEF.md
# Tagged Four-Operand Difference Unit

This block collects four unsigned 4-bit operands, named A, B, C and D, over a single shared data port. Each transfer carries a 2-bit tag naming the operand it fills, and a load strobe marks the cycles in which the port holds a real value. The operands may come in any order. The block counts which tags it has received. When every tag has been seen, it forms (A+B)-(C+D). It then presents the result on a 5-bit output, with a valid flag that is high for one clock cycle.

The design splits into two parts. The controller holds the sequencing state and a four-bit record of received tags. The datapath holds the operand registers, two ripple adders and a ripple subtractor built from full-adder cells. The block's environment guarantees three things: each operand is sent once per computation, nothing new is sent before valid has been seen, and (A+B) is never below (C+D). Any load offered while a computation is in flight is dropped.

Top module: `opd_collector`

## Requirements
- R1: A load cycle in the collecting phase writes `data_in` into the operand register named by `tag`, with encoding 00 = A, 01 = B, 10 = C, 11 = D. A repeated tag in one round overwrites the earlier value.
- R2: Cycles with `load` low change no operand and no received-tag record, whatever `data_in` and `tag` carry.
- R3: The result does not depend on the order in which the four operands arrive.
- R4: `valid` stays low until all four distinct tags have been captured. Three captures, even if one tag repeats, never produce a result.
- R5: `valid` goes high on the second rising edge after the edge that captured the last missing operand. This is well inside a ten-cycle limit.
- R6: `valid` is high for exactly one clock cycle per computation.
- R7: `result` equals (A+B)-(C+D) as a 5-bit unsigned value. The range runs from 0 up to 30.
- R8: `result` keeps its value after `valid` drops, until the next computation completes.
- R9: While `rst_n` is low at a rising edge, the block returns to collecting with no tags recorded, `valid` low and `result` zero. Operands captured before the reset are discarded.
- R10: Loads offered from the edge after the last operand up to and including the edge that ends the `valid` cycle are ignored. They neither record a tag nor count toward the next round.
- R11: After `valid`, the received-tag record is empty, so a new round needs four fresh captures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, sampled on the clock edge |
| data_in | input | 4 | Unsigned operand value |
| tag | input | 2 | Operand selector: 00 A, 01 B, 10 C, 11 D |
| load | input | 1 | Qualifies `data_in` and `tag` on this edge |
| result | output | 5 | (A+B)-(C+D), unsigned |
| valid | output | 1 | One-cycle flag marking a fresh `result` |

## Verification
The only result of interest is the valid pulse and its value. It appears after the second rising edge following the edge that completes the tag set, and it falls after the third. The bench's cycle model schedules that pulse with a two-edge countdown and compares both outputs at every falling edge. The named checks step through falling edges from the completing capture: low, low, high with the value, then low with the value held. Loads offered inside that window, and rounds left one tag short, are followed by several quiet cycles in which `valid` must stay low.

// File: rtl/opd_pkg.sv
package opd_pkg;

  localparam int NUM_OPS = 4;
  localparam int TAG_W   = 2;

  localparam logic [TAG_W-1:0] TAG_A = 2'd0;
  localparam logic [TAG_W-1:0] TAG_B = 2'd1;
  localparam logic [TAG_W-1:0] TAG_C = 2'd2;
  localparam logic [TAG_W-1:0] TAG_D = 2'd3;

  typedef enum logic [1:0] {
    ST_COLLECT = 2'd0,
    ST_COMPUTE = 2'd1,
    ST_DONE    = 2'd2
  } ctl_state_t;

endpackage

// File: rtl/opd_fa.sv
module opd_fa (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  always_comb begin
    s  = a ^ b ^ ci;
    co = (a & b) | (ci & (a ^ b));
  end
endmodule

// File: rtl/opd_rca.sv
// Ripple adder of full-adder cells; INVERT_B with ci=1 gives a - b.
module opd_rca #(
  parameter int W        = 5,
  parameter bit INVERT_B = 1'b0
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s
);
  logic [W-1:0] b_eff;
  logic [W-1:0] carry;

  assign b_eff    = INVERT_B ? ~b : b;
  assign carry[0] = ci;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i < W - 1) begin : g_mid
      opd_fa u_fa (
        .a (a[i]),
        .b (b_eff[i]),
        .ci(carry[i]),
        .s (s[i]),
        .co(carry[i+1])
      );
    end else begin : g_top
      // final carry is not needed: result is modulo 2^W
      assign s[i] = a[i] ^ b_eff[i] ^ carry[i];
    end
  end
endmodule

// File: rtl/opd_ctrl.sv
module opd_ctrl
  import opd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TAG_W-1:0]   tag,
  input  logic               load,
  output logic [NUM_OPS-1:0] wr_en,
  output logic               ld_result,
  output logic               valid
);
  ctl_state_t         state_q, state_d;
  logic [NUM_OPS-1:0] seen_q, seen_d;
  logic               seen_en;
  logic               all_seen;
  logic               accept;

  always_comb begin
    all_seen  = &seen_q;
    accept    = (state_q == ST_COLLECT) && load && !all_seen;
    wr_en     = accept ? (NUM_OPS'(1) << tag) : '0;
    ld_result = (state_q == ST_COMPUTE);
    valid     = (state_q == ST_DONE);
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_COLLECT: if (all_seen) state_d = ST_COMPUTE;
      ST_COMPUTE: state_d = ST_DONE;
      ST_DONE:    state_d = ST_COLLECT;
      default:    state_d = ST_COLLECT;
    endcase
  end

  always_comb begin
    seen_en = accept || (state_q == ST_DONE);
    seen_d  = (state_q == ST_DONE) ? '0 : (seen_q | wr_en);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_COLLECT;
      seen_q  <= '0;
    end else begin
      state_q <= state_d;
      if (seen_en) seen_q <= seen_d;
    end
  end

  assert_one_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en));
  assert_all_tags_before_compute_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ld_result |-> (&seen_q));
  assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);
  assert_record_cleared_R11: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> (seen_q == '0));
  assert_busy_no_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_result || valid) |-> (wr_en == '0));
endmodule

// File: rtl/opd_dp.sv
module opd_dp
  import opd_pkg::*;
#(
  parameter int DATA_W = 4,
  localparam int RES_W = DATA_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DATA_W-1:0]  data_in,
  input  logic [NUM_OPS-1:0] wr_en,
  input  logic               ld_result,
  output logic [RES_W-1:0]   result
);
  logic [DATA_W-1:0] opnd_q [NUM_OPS];
  logic [RES_W-1:0]  sum_ab, sum_cd, diff;
  logic [RES_W-1:0]  result_q;

  for (genvar k = 0; k < NUM_OPS; k++) begin : g_opnd
    always_ff @(posedge clk) begin
      if (!rst_n)        opnd_q[k] <= '0;
      else if (wr_en[k]) opnd_q[k] <= data_in;
    end
  end

  opd_rca #(.W(RES_W), .INVERT_B(1'b0)) u_add_ab (
    .a ({1'b0, opnd_q[TAG_A]}),
    .b ({1'b0, opnd_q[TAG_B]}),
    .ci(1'b0),
    .s (sum_ab)
  );

  opd_rca #(.W(RES_W), .INVERT_B(1'b0)) u_add_cd (
    .a ({1'b0, opnd_q[TAG_C]}),
    .b ({1'b0, opnd_q[TAG_D]}),
    .ci(1'b0),
    .s (sum_cd)
  );

  opd_rca #(.W(RES_W), .INVERT_B(1'b1)) u_sub (
    .a (sum_ab),
    .b (sum_cd),
    .ci(1'b1),
    .s (diff)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         result_q <= '0;
    else if (ld_result) result_q <= diff;
  end

  assign result = result_q;

  logic [RES_W-1:0] chk_expect;
  always_comb chk_expect = RES_W'({1'b0, opnd_q[TAG_A]}) + RES_W'({1'b0, opnd_q[TAG_B]})
                         - RES_W'({1'b0, opnd_q[TAG_C]}) - RES_W'({1'b0, opnd_q[TAG_D]});

  assert_difference_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ld_result |=> (result_q == $past(chk_expect)));
  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_result |=> $stable(result_q));
endmodule

// File: rtl/opd_collector.sv
module opd_collector
  import opd_pkg::*;
#(
  parameter int DATA_W = 4,
  localparam int RES_W = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] data_in,
  input  logic [TAG_W-1:0]  tag,
  input  logic              load,
  output logic [RES_W-1:0]  result,
  output logic              valid
);
  logic [NUM_OPS-1:0] wr_en;
  logic               ld_result;

  opd_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .tag      (tag),
    .load     (load),
    .wr_en    (wr_en),
    .ld_result(ld_result),
    .valid    (valid)
  );

  opd_dp #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .data_in  (data_in),
    .wr_en    (wr_en),
    .ld_result(ld_result),
    .result   (result)
  );
endmodule

// File: tb/opd_collector_test.sv
`timescale 1ns/1ps
module opd_collector_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] data_in = '0;
  logic [1:0] tag = '0;
  logic       load = 1'b0;
  logic [4:0] result;
  logic       valid;

  int vectors = 0;
  int miscompares = 0;
  bit cmp_on = 1'b0;

  always #10 clk = ~clk;

  opd_collector uut (
    .clk(clk), .rst_n(rst_n), .data_in(data_in), .tag(tag),
    .load(load), .result(result), .valid(valid)
  );

  // Behavioural reference: tag record, stored values, two-edge countdown
  int         m_mask = 0;
  int         m_val [4] = '{0, 0, 0, 0};
  int         m_cd = 0;
  bit         m_valid = 1'b0;
  logic [4:0] m_res = '0;

  always @(posedge clk) begin : model
    bit was_valid;
    int tmp;
    if (!rst_n) begin
      m_mask = 0; m_cd = 0; m_valid = 1'b0; m_res = '0;
      for (int i = 0; i < 4; i++) m_val[i] = 0;
    end else begin
      was_valid = m_valid;
      m_valid = 1'b0;
      if (was_valid) m_mask = 0;
      else if (m_cd > 0) begin
        m_cd--;
        if (m_cd == 0) begin
          tmp = m_val[0] + m_val[1] - m_val[2] - m_val[3];
          m_res = tmp[4:0];
          m_valid = 1'b1;
        end
      end else if (load && m_mask != 15) begin
        m_val[tag] = int'(data_in);
        m_mask |= (1 << tag);
        if (m_mask == 15) m_cd = 2;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      vectors++;
      if (valid !== m_valid || result !== m_res) begin
        miscompares++;
        $display("FAIL R5 R6 R7 R8 cycle model: valid=%0b result=%0d expected valid=%0b result=%0d",
                 valid, result, m_valid, m_res);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input logic [1:0] t, input logic [3:0] v);
    @(negedge clk);
    tag = t; data_in = v; load = 1'b1;
    @(negedge clk);
    load = 1'b0; data_in = 4'hx ^ 4'h0; data_in = 4'h0;
  endtask

  // called at the falling edge right after the completing capture
  task automatic expect_round(input string req, input int exp);
    chk({req, " R5 low at +0"}, int'(valid), 0);
    @(negedge clk); chk({req, " R5 low at +1"}, int'(valid), 0);
    @(negedge clk); chk({req, " R5 high at +2"}, int'(valid), 1);
    chk({req, " R7 value"}, int'(result), exp);
    @(negedge clk); chk({req, " R6 single pulse"}, int'(valid), 0);
    chk({req, " R8 held"}, int'(result), exp);
  endtask

  task automatic quiet(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); chk(req, int'(valid), 0);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : stim
    int a, b, c, d, st, stp, e, t;
    int vals [4];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    chk("R9 reset valid", int'(valid), 0);
    chk("R9 reset result", int'(result), 0);

    // R1 in-order, R7
    put(2'd0, 4'd9); put(2'd1, 4'd7); put(2'd2, 4'd3); put(2'd3, 4'd2);
    expect_round("R1 in order", 11);

    // R3 reverse order, R7 maximum
    put(2'd3, 4'd0); put(2'd2, 4'd0); put(2'd1, 4'd15); put(2'd0, 4'd15);
    expect_round("R3 reverse order max", 30);

    // R2 load low ignored; R4 three tags are not enough
    put(2'd2, 4'd1); put(2'd0, 4'd8);
    @(negedge clk); tag = 2'd1; data_in = 4'd15;
    @(negedge clk); tag = 2'd3; data_in = 4'd15;
    @(negedge clk); tag = 2'd3; data_in = 4'd0;
    put(2'd3, 4'd2);
    quiet("R4 three tags no valid", 5);
    put(2'd1, 4'd4);
    expect_round("R2 load low ignored", 9);

    // R4 repeated tag, R1 overwrite
    put(2'd0, 4'd1); put(2'd0, 4'd12); put(2'd1, 4'd2); put(2'd2, 4'd5);
    quiet("R4 repeated tag no valid", 4);
    put(2'd3, 4'd6);
    expect_round("R1 overwrite", 3);

    // R10 loads during computation ignored, R11 fresh round needs four
    put(2'd0, 4'd10); put(2'd1, 4'd10); put(2'd2, 4'd1);
    @(negedge clk); tag = 2'd3; data_in = 4'd1; load = 1'b1;
    @(negedge clk); tag = 2'd0; data_in = 4'd5;
    chk("R10 completing capture", int'(valid), 0);
    @(negedge clk); chk("R10 busy +1", int'(valid), 0);
    @(negedge clk); chk("R10 busy +2 valid", int'(valid), 1);
    chk("R10 value", int'(result), 18);
    @(negedge clk); load = 1'b0;
    chk("R6 pulse ends", int'(valid), 0);
    put(2'd1, 4'd3); put(2'd2, 4'd2); put(2'd3, 4'd2);
    quiet("R11 R10 record empty after valid", 10);
    put(2'd0, 4'd7);
    expect_round("R11 fresh round", 6);

    // R9 reset mid-collection discards operands
    put(2'd0, 4'd4); put(2'd1, 4'd4); put(2'd2, 4'd1);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R9 mid reset result", int'(result), 0);
    put(2'd3, 4'd1);
    quiet("R9 discarded operands", 6);
    put(2'd0, 4'd2); put(2'd2, 4'd0); put(2'd1, 4'd3);
    expect_round("R9 after reset", 4);

    // R7 equal sums give zero
    put(2'd2, 4'd6); put(2'd1, 4'd5); put(2'd3, 4'd5); put(2'd0, 4'd6);
    expect_round("R7 zero", 0);

    // R3 varied orders and values
    e = 7;
    for (int r = 0; r < 24; r++) begin
      e = (e * 13 + 5) % 251; a = e % 16;
      e = (e * 13 + 5) % 251; b = e % 16;
      e = (e * 13 + 5) % 251; c = e % 16;
      e = (e * 13 + 5) % 251; d = e % 16;
      if (c + d > a + b) begin t = a; a = c; c = t; t = b; b = d; d = t; end
      vals = '{a, b, c, d};
      st = r % 4; stp = (r % 2 == 0) ? 1 : 3;
      for (int k = 0; k < 4; k++) begin
        t = (st + k * stp) % 4;
        put(2'(t), 4'(vals[t]));
      end
      expect_round("R3 shuffled", a + b - c - d);
      repeat (r % 3) @(negedge clk);
    end

    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule